// File: doc/BRIEF.md
# Prescaled Auto-Reload Timebase

This block is a general-purpose up-counting timebase. A programmable prescaler divides the module clock. Each prescaler tick advances a main counter, which runs from zero up to a reload limit and then wraps to zero. The wrap raises an overflow. The overflow, or a software update request, produces an update event. On an update event the buffered prescale value and, when buffering is on, the buffered reload value become active.

Software reaches the block through a small word-addressed register port with a single-cycle write strobe and a combinational read. The block has three outputs. The first is an update interrupt request. The second is a one-cycle update DMA request. The third is a trigger output whose source is selectable. The control register adds four behaviours: updates can be suppressed, only overflows can be made to set the flag, the timer can stop itself after one period, and the reload value can be double-buffered.

The counting control is a two-state machine. **ST_IDLE** holds the count enable low. Its transition **start** goes to ST_RUN on the first clock edge that sees the run bit set. **ST_RUN** enables counting. Its transition **halt** returns to ST_IDLE when the run bit is found clear, whether software cleared it or a one-pulse update did.

Top module: `pulse_timebase`

## Requirements
- R1: After reset the reload register reads 0xFFFF, and the control, enable, status, count and prescale registers read 0. The irq, dma_req and trig_out outputs are all 0. Register word addresses are: control 0, enables 1, status 2, event 3, count 4, prescale 5, reload 6.
- R2: With the prescale value at 0, the count rises by one per cycle from 0 to the active reload value. On the next tick it wraps to 0, and that wrap sets status bit 0. While control bit 4 (reload buffering) is 0, a reload write becomes the limit at once.
- R3: The counter advances once every (P+1) cycles, where P is the active prescale value. A write to prescale register 5 is held in a buffer and becomes active only at the next update event.
- R4: While control bit 4 is 1, a reload write only changes the buffered value. That value reads back from register 6. It becomes the wrap limit only at the next update event.
- R5: Writing 1 to event register 3, bit 0, clears the count and the prescaler phase in that same cycle and produces an update event. Register 3 always reads 0.
- R6: While control bit 1 (update off) is 1, neither overflow nor the event register produces an update. The flag is not set and the prescale buffer is not loaded. A write to the event register still clears the count.
- R7: While control bit 2 (overflow only) is 1, an update from the event register loads the active values but does not set the flag or pulse dma_req. An overflow still does both.
- R8: While control bit 3 (one-pulse) is 1, an update event clears the run bit, control bit 0. The count then stays at the value it wrapped to.
- R9: The count enable rises one cycle after the run bit is set. The first count step therefore lands two cycles after the write that set the run bit.
- R10: While the active reload value is 0 the count does not advance. A value written into count register 4 is then held.
- R11: Control bits 10:8 select the trigger source: 0 selects the event-register pulse, 1 the count enable and 2 the update event. trig_out is a registered copy of that source, one cycle behind it.
- R12: Status bit 0 stays set until software writes 0 to it; writing 1 has no effect. irq equals the flag ANDed with enables bit 0. dma_req is a one-cycle pulse on each flag-setting update while enables bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Update interrupt request |
| dma_req | output | 1 | Update DMA request pulse |
| trig_out | output | 1 | Selected trigger output |

## Verification
Directed scenarios go after the cycle on which each change takes effect. If the prescale value were applied on write instead of at the update event, the count before the software update would advance at the wrong rate. If the reload limit ignored buffering, the counter would wrap early in buffered mode. A design that let update-off block only the flag, and not the loading of the buffers, would show the new division ratio after a software update. A design that let overflow-only mode also suppress overflow flags would never raise dma_req. Further checks count the exact cycle of the one-pulse stop, the single-cycle enable delay and each trigger source, so an extra or missing register stage shows up as a one-cycle shift.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    // Register word addresses
    localparam int A_CTRL   = 0;
    localparam int A_ENABLE = 1;
    localparam int A_STATUS = 2;
    localparam int A_EVENT  = 3;
    localparam int A_COUNT  = 4;
    localparam int A_PSC    = 5;
    localparam int A_RELOAD = 6;

    // Control register bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_UPD_OFF = 1;
    localparam int CB_OVF_ONL = 2;
    localparam int CB_SINGLE  = 3;
    localparam int CB_BUF     = 4;
    localparam int CB_TSEL_LO = 8;
    localparam int TSEL_W     = 3;

    // Trigger source codes
    localparam logic [TSEL_W-1:0] TSEL_SWUPD = 3'd0;
    localparam logic [TSEL_W-1:0] TSEL_CNTEN = 3'd1;
    localparam logic [TSEL_W-1:0] TSEL_UPD   = 3'd2;

    typedef struct packed {
        logic [TSEL_W-1:0] trig_sel;
        logic              reload_buf;
        logic              single;
        logic              ovf_only;
        logic              upd_off;
        logic              run;
    } ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag_set,
    input  logic              stop_req,
    output ctrl_t             ctrl,
    output logic              irq_en,
    output logic              dma_en,
    output logic              flag,
    output logic [PSC_W-1:0]  psc_pre,
    output logic [CNT_W-1:0]  arr_pre,
    output logic              sw_ug,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata
);

    logic sel_ctrl, sel_en, sel_stat, sel_evt, sel_cnt, sel_psc, sel_rld;

    always_comb begin
        sel_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
        sel_en   = bus_wr && (bus_addr == ADDR_W'(A_ENABLE));
        sel_stat = bus_wr && (bus_addr == ADDR_W'(A_STATUS));
        sel_evt  = bus_wr && (bus_addr == ADDR_W'(A_EVENT));
        sel_cnt  = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
        sel_psc  = bus_wr && (bus_addr == ADDR_W'(A_PSC));
        sel_rld  = bus_wr && (bus_addr == ADDR_W'(A_RELOAD));
    end

    assign sw_ug     = sel_evt && bus_wdata[0];
    assign cnt_wr    = sel_cnt;
    assign cnt_wdata = bus_wdata[CNT_W-1:0];

    // Control register: a bus write wins over the one-pulse stop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (sel_ctrl) begin
            ctrl.run        <= bus_wdata[CB_RUN];
            ctrl.upd_off    <= bus_wdata[CB_UPD_OFF];
            ctrl.ovf_only   <= bus_wdata[CB_OVF_ONL];
            ctrl.single     <= bus_wdata[CB_SINGLE];
            ctrl.reload_buf <= bus_wdata[CB_BUF];
            ctrl.trig_sel   <= bus_wdata[CB_TSEL_LO +: TSEL_W];
        end else if (stop_req) begin
            ctrl.run <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            dma_en <= 1'b0;
        end else if (sel_en) begin
            irq_en <= bus_wdata[0];
            dma_en <= bus_wdata[1];
        end
    end

    // Sticky flag: hardware set beats a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (sel_stat && !bus_wdata[0]) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_pre <= '0;
            arr_pre <= '1;
        end else begin
            if (sel_psc) psc_pre <= bus_wdata[PSC_W-1:0];
            if (sel_rld) arr_pre <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            A_CTRL: begin
                bus_rdata[CB_RUN]               = ctrl.run;
                bus_rdata[CB_UPD_OFF]           = ctrl.upd_off;
                bus_rdata[CB_OVF_ONL]           = ctrl.ovf_only;
                bus_rdata[CB_SINGLE]            = ctrl.single;
                bus_rdata[CB_BUF]               = ctrl.reload_buf;
                bus_rdata[CB_TSEL_LO +: TSEL_W] = ctrl.trig_sel;
            end
            A_ENABLE: begin
                bus_rdata[0] = irq_en;
                bus_rdata[1] = dma_en;
            end
            A_STATUS: bus_rdata[0] = flag;
            A_COUNT:  bus_rdata[CNT_W-1:0] = cnt_val;
            A_PSC:    bus_rdata[PSC_W-1:0] = psc_pre;
            A_RELOAD: bus_rdata[CNT_W-1:0] = arr_pre;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             clear,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_pre,
    output logic             tick
);

    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] psc_cnt;
    logic             at_end;

    assign at_end = (psc_cnt >= psc_act);
    assign tick   = cnt_en && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_act <= '0;
        end else if (load) begin
            psc_act <= psc_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_cnt <= '0;
        end else if (clear) begin
            psc_cnt <= '0;
        end else if (cnt_en) begin
            psc_cnt <= at_end ? '0 : psc_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ptb_core.sv
module ptb_core
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic             upd_off,
    input  logic             ovf_only,
    input  logic             reload_buf,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic             tick,
    input  logic             sw_ug,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_en,
    output logic             uev,
    output logic             flag_set,
    output logic [CNT_W-1:0] arr_eff
);

    run_state_e state_q, state_d;
    logic [CNT_W-1:0] arr_act;
    logic             advance;
    logic             ovf;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start (IDLE->RUN), halt (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_bit)  state_d = ST_RUN;
            ST_RUN:  if (!run_bit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the run machine
    always_comb begin
        cnt_en = 1'b0;
        unique case (state_q)
            ST_IDLE: cnt_en = 1'b0;
            ST_RUN:  cnt_en = run_bit;
            default: cnt_en = 1'b0;
        endcase
    end

    assign arr_eff  = reload_buf ? arr_act : arr_pre;
    assign advance  = tick && (arr_eff != '0);
    assign ovf      = advance && (cnt == arr_eff);
    assign uev      = !upd_off && (ovf || sw_ug);
    assign flag_set = uev && (ovf || !ovf_only);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sw_ug) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
        end else if (advance) begin
            cnt <= ovf ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_act <= '1;
        end else if (!reload_buf || uev) begin
            arr_act <= arr_pre;
        end
    end

endmodule

// File: rtl/pulse_timebase.sv
module pulse_timebase
    import ptb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_req,
    output logic              trig_out
);

    ctrl_t            ctrl;
    logic             irq_en, dma_en, flag;
    logic [PSC_W-1:0] psc_pre;
    logic [CNT_W-1:0] arr_pre, arr_eff, cnt, cnt_wdata;
    logic             sw_ug, cnt_wr, tick, cnt_en, uev, flag_set, stop_req;
    logic             run_bit, upd_off, single;
    logic             trig_src;

    assign run_bit  = ctrl.run;
    assign upd_off  = ctrl.upd_off;
    assign single   = ctrl.single;
    assign stop_req = single && uev;

    ptb_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_val(cnt), .flag_set(flag_set), .stop_req(stop_req),
        .ctrl(ctrl), .irq_en(irq_en), .dma_en(dma_en), .flag(flag),
        .psc_pre(psc_pre), .arr_pre(arr_pre),
        .sw_ug(sw_ug), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata)
    );

    ptb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .cnt_en(cnt_en), .clear(sw_ug), .load(uev),
        .psc_pre(psc_pre), .tick(tick)
    );

    ptb_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_bit(run_bit), .upd_off(upd_off), .ovf_only(ctrl.ovf_only),
        .reload_buf(ctrl.reload_buf), .arr_pre(arr_pre),
        .tick(tick), .sw_ug(sw_ug), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt(cnt), .cnt_en(cnt_en), .uev(uev), .flag_set(flag_set),
        .arr_eff(arr_eff)
    );

    always_comb begin
        unique case (ctrl.trig_sel)
            TSEL_SWUPD: trig_src = sw_ug;
            TSEL_CNTEN: trig_src = cnt_en;
            TSEL_UPD:   trig_src = uev;
            default:    trig_src = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_out <= 1'b0;
            dma_req  <= 1'b0;
        end else begin
            trig_out <= trig_src;
            dma_req  <= flag_set && dma_en;
        end
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  arr_eff,
    input logic              tick,
    input logic              sw_ug,
    input logic              cnt_wr,
    input logic              dma_req,
    input logic              flag,
    input logic              upd_off,
    input logic              uev,
    input logic              single,
    input logic              run_bit,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cnt_en
);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && arr_eff != '0 && cnt == arr_eff && !sw_ug && !cnt_wr) |=> (cnt == '0));

    p_swug_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ug |=> (cnt == '0));

    p_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_off && !flag) |=> !flag);

    p_single_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (single && uev && !(bus_wr && bus_addr == '0)) |=> !run_bit);

    p_en_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_en) |-> $past(run_bit));

    p_zero_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_eff == '0 && !sw_ug && !cnt_wr) |=> $stable(cnt));

    p_dma_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> flag);

endmodule

bind pulse_timebase ptb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .arr_eff(arr_eff), .tick(tick),
    .sw_ug(sw_ug), .cnt_wr(cnt_wr), .dma_req(dma_req), .flag(flag),
    .upd_off(upd_off), .uev(uev), .single(single), .run_bit(run_bit),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .cnt_en(cnt_en)
);

// File: tb/test_pulse_timebase.sv
`timescale 1ns/1ps
module test_pulse_timebase;

    localparam logic [2:0] A_CTRL = 3'd0, A_EN = 3'd1, A_STAT = 3'd2,
                           A_EVT = 3'd3, A_CNT = 3'd4, A_PSC = 3'd5, A_RLD = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, dma_req, trig_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_timebase i_pulse_timebase (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_req(dma_req), .trig_out(trig_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0000);
        rd(A_EN, v);   chk("R1 enables", v, 16'h0000);
        rd(A_STAT, v); chk("R1 status", v, 16'h0000);
        rd(A_CNT, v);  chk("R1 count", v, 16'h0000);
        rd(A_PSC, v);  chk("R1 prescale", v, 16'h0000);
        rd(A_RLD, v);  chk("R1 reload", v, 16'hFFFF);
        chk("R1 outputs", {13'd0, irq, dma_req, trig_out}, 16'h0000);
    endtask

    task automatic t_basic_count();
        logic [15:0] v;
        do_reset();
        wr(A_RLD, 16'd5);
        wr(A_EN, 16'h0003);
        wr(A_CTRL, 16'h0001);
        wait_n(6);
        rd(A_CNT, v);  chk("R2 count at limit", v, 16'd5);
        rd(A_STAT, v); chk("R2 flag before wrap", v, 16'd0);
        wait_n(1);
        rd(A_CNT, v);  chk("R2 wrap to zero", v, 16'd0);
        rd(A_STAT, v); chk("R2 flag on wrap", v, 16'd1);
        chk("R12 irq on flag", {15'd0, irq}, 16'd1);
        chk("R12 dma pulse high", {15'd0, dma_req}, 16'd1);
        wait_n(1);
        chk("R12 dma pulse one cycle", {15'd0, dma_req}, 16'd0);
        rd(A_CNT, v);  chk("R2 count after wrap", v, 16'd1);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v); chk("R12 write 1 keeps flag", v, 16'd1);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R12 write 0 clears flag", v, 16'd0);
        chk("R12 irq follows flag", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        do_reset();
        wr(A_RLD, 16'd1000);
        wr(A_PSC, 16'd3);
        wr(A_CTRL, 16'h0001);
        wait_n(5);
        rd(A_CNT, v); chk("R3 old ratio until update", v, 16'd4);
        rd(A_PSC, v); chk("R3 prescale reads buffered value", v, 16'd3);
        wr(A_EVT, 16'h0001);
        rd(A_CNT, v); chk("R5 event clears count", v, 16'd0);
        rd(A_EVT, v); chk("R5 event reads zero", v, 16'd0);
        rd(A_STAT, v); chk("R5 event sets flag", v, 16'd1);
        wait_n(7);
        rd(A_CNT, v); chk("R3 divide by 4 first step", v, 16'd1);
        wait_n(1);
        rd(A_CNT, v); chk("R3 divide by 4 second step", v, 16'd2);
    endtask

    task automatic t_reload_buffered();
        logic [15:0] v;
        do_reset();
        wr(A_CTRL, 16'h0011);
        wr(A_RLD, 16'd3);
        wait_n(12);
        rd(A_CNT, v); chk("R4 no early wrap", v, 16'd12);
        rd(A_RLD, v); chk("R4 reload reads buffered", v, 16'd3);
        wr(A_EVT, 16'h0001);
        wr(A_STAT, 16'h0000);
        wait_n(3);
        rd(A_CNT, v);  chk("R4 new limit after update", v, 16'd0);
        rd(A_STAT, v); chk("R4 wrap flag at new limit", v, 16'd1);
    endtask

    task automatic t_update_off();
        logic [15:0] v;
        do_reset();
        wr(A_EN, 16'h0001);
        wr(A_RLD, 16'd1000);
        wr(A_PSC, 16'd1);
        wr(A_CTRL, 16'h0003);
        wait_n(4);
        rd(A_CNT, v); chk("R6 counting", v, 16'd3);
        wr(A_EVT, 16'h0001);
        rd(A_CNT, v);  chk("R6 event still clears count", v, 16'd0);
        rd(A_STAT, v); chk("R6 event no flag", v, 16'd0);
        wait_n(3);
        rd(A_CNT, v); chk("R6 prescale not loaded", v, 16'd3);
        wr(A_RLD, 16'd2);
        wr(A_EVT, 16'h0001);
        wait_n(6);
        rd(A_CNT, v);  chk("R6 wraps continue", v, 16'd0);
        rd(A_STAT, v); chk("R6 overflow no flag", v, 16'd0);
        chk("R6 irq low", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_ovf_only();
        logic [15:0] v;
        do_reset();
        wr(A_RLD, 16'd4);
        wr(A_EN, 16'h0003);
        wr(A_PSC, 16'd2);
        wr(A_CTRL, 16'h0005);
        wr(A_EVT, 16'h0001);
        rd(A_STAT, v); chk("R7 event no flag", v, 16'd0);
        chk("R7 event no dma", {15'd0, dma_req}, 16'd0);
        wait_n(6);
        rd(A_CNT, v); chk("R7 event loaded prescale", v, 16'd2);
        wait_n(9);
        chk("R7 overflow dma", {15'd0, dma_req}, 16'd1);
        rd(A_CNT, v);  chk("R7 overflow wrap", v, 16'd0);
        rd(A_STAT, v); chk("R7 overflow sets flag", v, 16'd1);
    endtask

    task automatic t_one_pulse();
        logic [15:0] v;
        do_reset();
        wr(A_RLD, 16'd3);
        wr(A_CTRL, 16'h0009);
        wait_n(4);
        rd(A_CNT, v); chk("R8 reaches limit", v, 16'd3);
        wait_n(1);
        rd(A_CNT, v); chk("R8 wraps", v, 16'd0);
        wait_n(5);
        rd(A_CNT, v);  chk("R8 stopped after update", v, 16'd0);
        rd(A_CTRL, v); chk("R8 run bit cleared", v, 16'h0008);
        rd(A_STAT, v); chk("R8 flag set", v, 16'd1);
    endtask

    task automatic t_zero_reload();
        logic [15:0] v;
        do_reset();
        wr(A_RLD, 16'd0);
        wr(A_CTRL, 16'h0001);
        wait_n(10);
        rd(A_CNT, v);  chk("R10 blocked at zero", v, 16'd0);
        rd(A_STAT, v); chk("R10 no flag", v, 16'd0);
        wr(A_CNT, 16'd7);
        wait_n(5);
        rd(A_CNT, v); chk("R10 written count held", v, 16'd7);
    endtask

    task automatic t_trigger();
        logic [15:0] v;
        // source 1: count enable, also shows the enable delay
        do_reset();
        wr(A_CTRL, 16'h0101);
        wait_n(1);
        chk("R11 enable source delayed", {15'd0, trig_out}, 16'd0);
        rd(A_CNT, v); chk("R9 no step yet", v, 16'd0);
        wait_n(1);
        chk("R11 enable source high", {15'd0, trig_out}, 16'd1);
        rd(A_CNT, v); chk("R9 first step", v, 16'd1);
        // source 2: update event
        do_reset();
        wr(A_RLD, 16'd2);
        wr(A_CTRL, 16'h0201);
        wait_n(3);
        chk("R11 update source idle", {15'd0, trig_out}, 16'd0);
        wait_n(1);
        chk("R11 update source pulse", {15'd0, trig_out}, 16'd1);
        wait_n(1);
        chk("R11 update source ends", {15'd0, trig_out}, 16'd0);
        // source 0: software update pulse
        do_reset();
        wr(A_EVT, 16'h0001);
        chk("R11 event source pulse", {15'd0, trig_out}, 16'd1);
        wait_n(1);
        chk("R11 event source ends", {15'd0, trig_out}, 16'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_count();
        t_prescale();
        t_reload_buffered();
        t_update_off();
        t_ovf_only();
        t_one_pulse();
        t_zero_reload();
        t_trigger();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule